// File: doc/BRIEF.md
# UART Status and Interrupt Unit

This block keeps the status word of a UART and builds its interrupt requests. The receiver tells it when a character has finished, at the stop bits, and whether that character had a parity mismatch, a missing or short stop bit, or was zero throughout. The transmitter reports buffer writes, transfers of the buffer into the shift register, and whether the shift register is idle. Two modem inputs, clear-to-send and data-set-ready, are synchronised inside the block, and any change on either one is latched as a modem-change flag.

The status word gathers eight flags. A single shared interrupt line is raised only by a finished transmission, or by a modem change when the modem interrupt enable is also set, and both need the global enable. Data-ready and transmit-buffer-empty never reach the shared line. They come out on their own request pins, so a CPU or an external interrupt controller can serve them separately. Read strobes from the register decode clear the flags: a status read clears the receive error flags, a receive buffer read clears data-ready, and a modem register read clears the modem-change flag.

Top module: `uart_stat_irq`

## Requirements
- R1: After reset the status word is 0x02, with only buffer-empty set, and the interrupt line is low. Bit layout of `status_o`: bit 0 data-ready, bit 1 buffer-empty, bit 2 transmission-complete, bit 3 modem-change, bit 4 parity error, bit 5 framing error, bit 6 overrun, bit 7 break.
- R2: Each character completion loads parity error (bit 4), framing error (bit 5) and break (bit 7) from that character's indications and replaces the earlier values. The result is visible on the cycle after the completion pulse.
- R3: Overrun (bit 6) is set when a character completes while data-ready is set and no receive buffer read occurs in that same cycle. It then stays set until it is cleared.
- R4: A status read clears bits 4 to 7. A character completion in the same cycle takes priority and loads its own values.
- R5: Data-ready is set by every character completion, break characters included. A receive buffer read clears it, unless a completion arrives in the same cycle.
- R6: A change on either modem input sets modem-change on the third clock edge after the change. A modem register read clears the flag, unless a new change is detected in that cycle.
- R7: A buffer write clears buffer-empty. A transfer into the shift register sets it again, unless a write happens in the same cycle.
- R8: A buffer write clears transmission-complete. The flag is set on the edge after the buffer is empty and the shift register is idle, and only if a character has been written since the flag last set. It is never set while buffer-empty is clear.
- R9: `intr_o` equals inten AND (transmission-complete OR (mien AND modem-change)), with no added latency.
- R10: Data-ready and buffer-empty do not affect `intr_o`. `dr_req_o` and `tbre_req_o` follow those two flags exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_char_done | input | 1 | One-cycle pulse when a character's stop bits have been received |
| rx_parity_bad | input | 1 | Parity mismatch on the completing character |
| rx_stop_bad | input | 1 | Stop bit missing or too short on the completing character |
| rx_all_zero | input | 1 | Completing character was zero in every bit, parity and stop included |
| rbr_read | input | 1 | Receive buffer read strobe |
| usr_read | input | 1 | Status register read strobe |
| msr_read | input | 1 | Modem status register read strobe |
| tbr_write | input | 1 | Transmit buffer write strobe |
| tx_load | input | 1 | Transmit buffer moved into the shift register |
| tx_shift_idle | input | 1 | Transmit shift register empty |
| cts_in | input | 1 | Asynchronous clear-to-send input |
| dsr_in | input | 1 | Asynchronous data-set-ready input |
| mien | input | 1 | Modem-change interrupt enable |
| inten | input | 1 | Global interrupt enable |
| status_o | output | 8 | Status word, layout given in R1 |
| intr_o | output | 1 | Shared interrupt request |
| dr_req_o | output | 1 | Data-ready request |
| tbre_req_o | output | 1 | Transmit-buffer-empty request |

## Verification
The bench sweeps every combination of the three receive indications, with data-ready both clear and set beforehand. A design that accumulated the error flags instead of replacing them, or that missed the overrun, would show the wrong upper nibble. It checks collisions of a read strobe with a completion in the same cycle, where a design with the wrong priority would lose a fresh character's flags or report a false overrun. It checks modem-change timing cycle by cycle across the synchroniser, and checks that completion does not assert before the shift register goes idle. A full sweep over the two enables and the two interrupt sources catches any leak of data-ready or buffer-empty into the shared line.

// File: rtl/uart_stat_pkg.sv
// Package: shared bit positions of the UART status word.
// Assumes: an 8-bit status word; positions are fixed by the register decode.
package uart_stat_pkg;
    localparam int STAT_W   = 8;
    localparam int BIT_DR   = 0;
    localparam int BIT_TBRE = 1;
    localparam int BIT_TC   = 2;
    localparam int BIT_MS   = 3;
    localparam int BIT_PE   = 4;
    localparam int BIT_FE   = 5;
    localparam int BIT_OE   = 6;
    localparam int BIT_BRK  = 7;

    typedef struct packed {
        logic oe;
        logic fe;
        logic pe;
        logic brk;
        logic dr;
    } rx_flags_t;
endpackage

// File: rtl/rx_error_flags.sv
// Receive-side flags: overrun, framing, parity, break and data-ready.
// Assumes: char_done is a single-cycle pulse given at the stop bits; the
// indications are valid in that same cycle.
module rx_error_flags
    import uart_stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      char_done,
    input  logic      par_bad,
    input  logic      stop_bad,
    input  logic      all_zero,
    input  logic      buf_rd,
    input  logic      stat_rd,
    output rx_flags_t flags_o
);
    rx_flags_t q;
    logic      overrun_now;

    // Overrun: the previous character is still unread as a new one completes.
    assign overrun_now = char_done && q.dr && !buf_rd;

    // Per-character error flags: a completion loads them, a status read clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pe  <= 1'b0;
            q.fe  <= 1'b0;
            q.brk <= 1'b0;
        end else if (char_done) begin
            q.pe  <= par_bad;
            q.fe  <= stop_bad;
            q.brk <= all_zero;
        end else if (stat_rd) begin
            q.pe  <= 1'b0;
            q.fe  <= 1'b0;
            q.brk <= 1'b0;
        end
    end

    // Overrun flag: sticky until a status read with no fresh overrun.
    always_ff @(posedge clk) begin
        if (!rst_n)           q.oe <= 1'b0;
        else if (overrun_now) q.oe <= 1'b1;
        else if (stat_rd)     q.oe <= 1'b0;
    end

    // Data-ready: set by any completion, cleared by a buffer read.
    always_ff @(posedge clk) begin
        if (!rst_n)         q.dr <= 1'b0;
        else if (char_done) q.dr <= 1'b1;
        else if (buf_rd)    q.dr <= 1'b0;
    end

    assign flags_o = q;

    assert_oe_on_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && flags_o.dr && !buf_rd) |=> flags_o.oe);
    assert_dr_on_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> flags_o.dr);
    assert_stat_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !char_done) |=> !(flags_o.oe || flags_o.fe || flags_o.pe || flags_o.brk));
endmodule

// File: rtl/modem_change_det.sv
// Synchronises the modem input lines and latches any change into one flag.
// Assumes: the lines are asynchronous and change slowly compared with clk.
// Edge detection is held off until the synchroniser has filled after reset.
module modem_change_det #(
    parameter int NLINES      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lines_in,
    input  logic              reg_rd,
    output logic              change_o
);
    localparam int PRIME_MAX = SYNC_STAGES + 1;
    localparam int PRIME_W   = $clog2(PRIME_MAX + 1);

    logic [NLINES-1:0]  sync_q [SYNC_STAGES];
    logic [NLINES-1:0]  prev_q;
    logic [PRIME_W-1:0] prime_q;
    logic               primed;
    logic               edge_seen;
    logic               flag_q;

    // Synchroniser chain, one register stage per generate step.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // First stage samples the raw lines.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= '0;
                else        sync_q[g] <= lines_in;
            end
        end else begin : g_next
            // Later stages follow the stage before them.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= '0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Previous synchronised value, used for the edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Fill counter: edges count only once the whole chain holds real samples.
    always_ff @(posedge clk) begin
        if (!rst_n)       prime_q <= '0;
        else if (!primed) prime_q <= prime_q + 1'b1;
    end

    assign primed    = (prime_q == PRIME_W'(PRIME_MAX));
    assign edge_seen = primed && (sync_q[SYNC_STAGES-1] != prev_q);

    // Change flag: set on an edge; a register read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (edge_seen) flag_q <= 1'b1;
        else if (reg_rd)    flag_q <= 1'b0;
    end

    assign change_o = flag_q;

    assert_edge_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> change_o);
    assert_read_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !edge_seen) |=> !change_o);
endmodule

// File: rtl/tx_status.sv
// Transmit-side flags: buffer-empty and transmission-complete.
// Assumes: load is a single-cycle pulse; the shift register reports not idle
// from the cycle of the load until its last stop bit has gone out.
module tx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic buf_wr,
    input  logic load,
    input  logic shift_idle,
    output logic tbre_o,
    output logic tc_o
);
    logic tbre_q;
    logic tc_q;
    logic pending_q;
    logic done_now;

    // Completion: a written character has drained from both buffer and shifter.
    assign done_now = pending_q && tbre_q && shift_idle && !buf_wr && !load;

    // Buffer-empty: a write fills the buffer, a transfer empties it.
    always_ff @(posedge clk) begin
        if (!rst_n)      tbre_q <= 1'b1;
        else if (buf_wr) tbre_q <= 1'b0;
        else if (load)   tbre_q <= 1'b1;
    end

    // Pending: a character has been written since completion was last reported.
    always_ff @(posedge clk) begin
        if (!rst_n)        pending_q <= 1'b0;
        else if (buf_wr)   pending_q <= 1'b1;
        else if (done_now) pending_q <= 1'b0;
    end

    // Transmission-complete: set on drain, cleared by the next write.
    always_ff @(posedge clk) begin
        if (!rst_n)        tc_q <= 1'b0;
        else if (buf_wr)   tc_q <= 1'b0;
        else if (done_now) tc_q <= 1'b1;
    end

    assign tbre_o = tbre_q;
    assign tc_o   = tc_q;

    assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> (!tbre_o && !tc_o));
    assert_load_sets_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !buf_wr) |=> tbre_o);
    assert_tc_needs_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> tbre_o);
endmodule

// File: rtl/uart_stat_irq.sv
// Top: assembles the UART status word and derives the shared interrupt and
// the two separate request outputs.
// Assumes: read and write strobes are single-cycle pulses from the bus decode.
module uart_stat_irq
    import uart_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_char_done,
    input  logic              rx_parity_bad,
    input  logic              rx_stop_bad,
    input  logic              rx_all_zero,
    input  logic              rbr_read,
    input  logic              usr_read,
    input  logic              msr_read,
    input  logic              tbr_write,
    input  logic              tx_load,
    input  logic              tx_shift_idle,
    input  logic              cts_in,
    input  logic              dsr_in,
    input  logic              mien,
    input  logic              inten,
    output logic [STAT_W-1:0] status_o,
    output logic              intr_o,
    output logic              dr_req_o,
    output logic              tbre_req_o
);
    rx_flags_t rx_f;
    logic      ms;
    logic      tbre;
    logic      tc;

    rx_error_flags u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .char_done(rx_char_done),
        .par_bad  (rx_parity_bad),
        .stop_bad (rx_stop_bad),
        .all_zero (rx_all_zero),
        .buf_rd   (rbr_read),
        .stat_rd  (usr_read),
        .flags_o  (rx_f)
    );

    modem_change_det #(.NLINES(2), .SYNC_STAGES(2)) u_modem (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_in({dsr_in, cts_in}),
        .reg_rd  (msr_read),
        .change_o(ms)
    );

    tx_status u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_wr    (tbr_write),
        .load      (tx_load),
        .shift_idle(tx_shift_idle),
        .tbre_o    (tbre),
        .tc_o      (tc)
    );

    // Status word packing, fixed positions from the package.
    always_comb begin
        status_o           = '0;
        status_o[BIT_DR]   = rx_f.dr;
        status_o[BIT_TBRE] = tbre;
        status_o[BIT_TC]   = tc;
        status_o[BIT_MS]   = ms;
        status_o[BIT_PE]   = rx_f.pe;
        status_o[BIT_FE]   = rx_f.fe;
        status_o[BIT_OE]   = rx_f.oe;
        status_o[BIT_BRK]  = rx_f.brk;
    end

    // Shared interrupt: only completion and gated modem change feed it.
    assign intr_o     = inten && (tc || (mien && ms));
    assign dr_req_o   = rx_f.dr;
    assign tbre_req_o = tbre;

    assert_intr_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !inten |-> !intr_o);
    assert_intr_ignores_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[BIT_TC] && !status_o[BIT_MS]) |-> !intr_o);
    assert_modem_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[BIT_TC] && !mien) |-> !intr_o);
endmodule

// File: tb/tb_uart_stat_irq.sv
module tb_uart_stat_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_char_done = 0, rx_parity_bad = 0, rx_stop_bad = 0, rx_all_zero = 0;
    logic       rbr_read = 0, usr_read = 0, msr_read = 0;
    logic       tbr_write = 0, tx_load = 0, tx_shift_idle = 1;
    logic       cts_in = 0, dsr_in = 0, mien = 0, inten = 0;
    logic [7:0] status_o;
    logic       intr_o, dr_req_o, tbre_req_o;
    int         n_tests = 0, n_fail = 0;
    bit         done = 0;

    uart_stat_irq dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rx_char(input logic p, input logic s, input logic z, input logic rd, input logic sr);
        rx_char_done = 1; rx_parity_bad = p; rx_stop_bad = s; rx_all_zero = z;
        rbr_read = rd; usr_read = sr;
        tick();
        rx_char_done = 0; rx_parity_bad = 0; rx_stop_bad = 0; rx_all_zero = 0;
        rbr_read = 0; usr_read = 0;
    endtask

    task automatic clear_rx();
        rbr_read = 1; usr_read = 1; tick(); rbr_read = 0; usr_read = 0;
    endtask

    task automatic set_tc(input logic v);
        tbr_write = 1; tick(); tbr_write = 0;
        if (v) begin
            tx_load = 1; tx_shift_idle = 0; tick(); tx_load = 0;
            tx_shift_idle = 1; tick();
        end
    endtask

    task automatic set_ms(input logic v);
        if (v) begin cts_in = ~cts_in; repeat (3) tick(); end
        else begin msr_read = 1; tick(); msr_read = 0; end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) tick();
        rst_n = 1;
        repeat (5) tick();
        // R1: reset state
        chk("R1 status after reset", status_o, 8'h02);
        chk("R1 intr after reset", intr_o, 0);

        // R2 R3 R5: sweep indications x prior data-ready
        for (int i = 0; i < 16; i++) begin
            clear_rx();
            if (i[3]) rx_char(1, 1, 1, 0, 0);
            rx_char(i[0], i[1], i[2], 0, 0);
            chk("R2 parity bit4", status_o[4], i[0]);
            chk("R2 framing bit5", status_o[5], i[1]);
            chk("R2 break bit7", status_o[7], i[2]);
            chk("R3 overrun bit6", status_o[6], i[3]);
            chk("R5 data-ready bit0", status_o[0], 1);
        end

        // R3: overrun sticky across a later clean character
        rx_char(0, 0, 0, 1, 0);
        chk("R3 overrun sticky", status_o[6], 1);
        // R4: status read clears error bits, data-ready untouched
        rx_char(1, 1, 1, 0, 0);
        usr_read = 1; tick(); usr_read = 0;
        chk("R4 status read clears bits 7:4", status_o[7:4], 0);
        chk("R5 data-ready kept on status read", status_o[0], 1);
        // R4: completion wins over same-cycle status read
        rx_char(1, 0, 1, 1, 1);
        chk("R4 completion beats status read", status_o[7:4], 4'b1001);
        chk("R3 no overrun with same-cycle buffer read", status_o[6], 0);
        // R5: buffer read clears data-ready
        rbr_read = 1; tick(); rbr_read = 0;
        chk("R5 buffer read clears data-ready", status_o[0], 0);
        chk("R10 dr_req follows data-ready", dr_req_o, 0);

        // R6: modem change timing, CTS then DSR
        clear_rx();
        cts_in = 1; tick(); tick();
        chk("R6 no flag after two edges", status_o[3], 0);
        tick();
        chk("R6 flag after third edge", status_o[3], 1);
        msr_read = 1; tick(); msr_read = 0;
        chk("R6 modem read clears", status_o[3], 0);
        dsr_in = 1; repeat (3) tick();
        chk("R6 DSR change sets flag", status_o[3], 1);
        set_ms(0);

        // R7 R8: transmit sequence
        tbr_write = 1; tick(); tbr_write = 0;
        chk("R7 write clears empty", status_o[2:1], 2'b00);
        chk("R10 tbre_req follows flag", tbre_req_o, 0);
        tx_load = 1; tx_shift_idle = 0; tick(); tx_load = 0;
        chk("R7 transfer sets empty", status_o[1], 1);
        chk("R8 no completion while shifting", status_o[2], 0);
        tick();
        chk("R8 still shifting", status_o[2], 0);
        tx_shift_idle = 1; tick();
        chk("R8 completion after idle", status_o[2], 1);
        tbr_write = 1; tick(); tbr_write = 0;
        chk("R8 write clears completion", status_o[2], 0);
        tx_load = 1; tbr_write = 1; tick(); tx_load = 0; tbr_write = 0;
        chk("R7 write beats transfer", status_o[1], 0);

        // R9: sweep sources x enables
        for (int s = 0; s < 4; s++) begin
            set_tc(s[0]);
            set_ms(s[1]);
            for (int e = 0; e < 4; e++) begin
                inten = e[0]; mien = e[1]; #1;
                chk("R9 intr equation", intr_o,
                    int'(e[0] && (s[0] || (e[1] && s[1]))));
            end
        end

        // R10: data-ready and buffer-empty set, no other source
        set_ms(0);
        set_tc(0);
        tx_load = 1; tx_shift_idle = 0; tick(); tx_load = 0;
        rx_char(0, 0, 0, 0, 0);
        inten = 1; mien = 1; #1;
        chk("R10 intr low with only requests", intr_o, 0);
        chk("R10 dr_req high", dr_req_o, 1);
        chk("R10 tbre_req high", tbre_req_o, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule